// File: doc/BRIEF.md
# SD Host Command Engine

This block drives the command line of an SD/SDIO host. On request it serializes a 48-bit command frame onto CMD, one bit per card-clock cycle, most significant bit first. If the selected response kind expects an answer, it listens for the card's start bit and shifts in a 48-bit or 136-bit response. It then checks the response CRC7, stores the payload in four 32-bit words and raises sticky status flags. The engine runs entirely on the card clock: one `clk` cycle is one card-clock period.

A six-state sequencer (Idle, Pend, Send, Wait, Receive, CmplWait) orders the work. A new command can only leave Idle after a guaranteed idle gap. An optional hold in Pend delays sending until the data path reports that its transfer has finished. An answer that never arrives is ended by a fixed timeout. A CE-ATA branch, after a good response, either waits for the card's completion signal or goes back to Pend. Dropping the engine enable aborts any activity.

Top module: `sdcmd_engine`

## Requirements
- R1: While reset is asserted, and right after it, `cmd_oe` is 0, `cmd_o` is 1, `flags_o` is 0 and all four response words are 0.
- R2: When a command is accepted, `cmd_oe` is high for exactly 48 cycles starting the next cycle. During that time `cmd_o` carries, MSB first, the frame {0, 1, cmd_index[5:0], cmd_arg[31:0], crc7, 1}. The crc7 uses the polynomial x^7+x^3+1, starts from zero and covers the first 40 frame bits. After the last bit, the sent flag `flags_o[0]` sets.
- R3: `cmd_go` is accepted only when `eng_en` is 1 and the engine has been in Idle for at least 8 cycles, counting the current one. An earlier `cmd_go` is ignored and produces no frame.
- R4: With `wait_data` set, an accepted command waits in Pend with `cmd_oe` low. The frame starts in the cycle after `data_done` is sampled high.
- R5: `rsp_kind` values 00 and 10 mean no response, and the engine goes back to Idle after the frame with no timeout. Value 01 selects a 48-bit response and value 11 a 136-bit response.
- R6: If `cmd_i` does not go low within 64 cycles after the frame ends, the timeout flag `flags_o[3]` sets after the 64th cycle and not before.
- R7: For a 48-bit response, the CRC7 covers response bits 47:8. `rsp_w0` receives bits 39:8 and the other words become 0. On success the ok flag `flags_o[1]` sets.
- R8: For a 136-bit response, the CRC7 covers bits 127:8. The words `rsp_w0`..`rsp_w3` receive bits 127:1, highest bits in `rsp_w0`, with bit 0 of `rsp_w3` forced to 0.
- R9: A CRC mismatch, or an end bit of 0, sets the CRC-fail flag `flags_o[2]` instead of the ok flag. With `rsp_nocrc` set, the CRC comparison is skipped.
- R10: After a good response with `ceata_mode`=1, `ceata_irq_en`=0 and `ceata_cmpl_wait`=1, the engine waits for `cmd_i` low. It then sets the completion flag `flags_o[4]` and returns to Idle.
- R11: After a good response with `ceata_mode`=1, `ceata_irq_en`=0 and `ceata_cmpl_wait`=0, the engine goes to Pend. There `data_done` starts sending the command again.
- R12: `eng_en` sampled low forces Idle at the next cycle from any state, so `cmd_oe` is low in the following cycle and no flag is set.
- R13: Flags are sticky. A 1 in `flag_clr` clears the matching flag in the next cycle. A set event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_en | input | 1 | Engine enable; low aborts to Idle |
| cmd_go | input | 1 | Request to issue a command |
| wait_data | input | 1 | Hold in Pend until data end before sending |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | 00/10 none, 01 short, 11 long |
| rsp_nocrc | input | 1 | Skip response CRC comparison |
| ceata_mode | input | 1 | CE-ATA command in progress |
| ceata_irq_en | input | 1 | CE-ATA interrupt enabled |
| ceata_cmpl_wait | input | 1 | Wait for CE-ATA completion signal |
| data_done | input | 1 | Data transfer finished |
| flag_clr | input | 5 | Per-flag clear mask |
| cmd_i | input | 1 | CMD line input |
| cmd_o | output | 1 | CMD line output value |
| cmd_oe | output | 1 | CMD line output enable |
| rsp_w0 | output | 32 | Response word, highest bits |
| rsp_w1 | output | 32 | Response word |
| rsp_w2 | output | 32 | Response word |
| rsp_w3 | output | 32 | Response word, lowest bits |
| flags_o | output | 5 | {cmpl, timeout, crc_fail, resp_ok, sent} |

## Verification
The bench probes the timeout boundary by checking the flag after 63 silent cycles and again after 64. An engine that counts one cycle off would set the flag early or late. It sends a `cmd_go` right after reset, which a design without the idle gap would turn into an immediate frame. Long responses carry non-zero reserved and content bits, so a CRC window that wrongly included the first eight bits would raise CRC-fail. Bad CRCs are sent with and without the skip option, and both CE-ATA branches and an abort in mid-frame are exercised. A wrong next state after Receive or a late abort shows up at once against the per-cycle reference model.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PEND = 3'd1,
        ST_SEND = 3'd2,
        ST_WAIT = 3'd3,
        ST_RECV = 3'd4,
        ST_CMPL = 3'd5
    } cmd_state_e;

    localparam int unsigned TX_BITS    = 48;
    localparam int unsigned SHORT_BITS = 48;
    localparam int unsigned LONG_BITS  = 136;
    localparam int unsigned CRC_W      = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
    localparam int unsigned FLAG_N     = 5;

    localparam int unsigned FL_SENT    = 0;
    localparam int unsigned FL_OK      = 1;
    localparam int unsigned FL_CRCERR  = 2;
    localparam int unsigned FL_TMO     = 3;
    localparam int unsigned FL_CMPL    = 4;

    function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    function automatic logic [CRC_W-1:0] crc7_frame(input logic [39:0] d);
        logic [CRC_W-1:0] c;
        c = '0;
        for (int i = 39; i >= 0; i--) begin
            c = crc7_step(c, d[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
    import sdcmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr) begin
            crc_d = '0;
        end else if (en) begin
            crc_d = crc7_step(crc_q, din);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= '0;
        end else begin
            crc_q <= crc_d;
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/sdcmd_flags.sv
module sdcmd_flags #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
    import sdcmd_pkg::*;
#(
    parameter int unsigned GAP_CYCLES  = 8,
    parameter int unsigned RSP_TIMEOUT = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        eng_en,
    input  logic        cmd_go,
    input  logic        wait_data,
    input  logic [5:0]  cmd_index,
    input  logic [31:0] cmd_arg,
    input  logic [1:0]  rsp_kind,
    input  logic        rsp_nocrc,
    input  logic        ceata_mode,
    input  logic        ceata_irq_en,
    input  logic        ceata_cmpl_wait,
    input  logic        data_done,
    input  logic [4:0]  flag_clr,
    input  logic        cmd_i,
    output logic        cmd_o,
    output logic        cmd_oe,
    output logic [31:0] rsp_w0,
    output logic [31:0] rsp_w1,
    output logic [31:0] rsp_w2,
    output logic [31:0] rsp_w3,
    output logic [4:0]  flags_o
);

    localparam int unsigned GAP_W     = $clog2(GAP_CYCLES + 1);
    localparam int unsigned TMO_W     = $clog2(RSP_TIMEOUT);
    localparam int unsigned POS_W     = $clog2(LONG_BITS);
    localparam int unsigned TXC_W     = $clog2(TX_BITS);
    localparam int unsigned RX_KEEP   = 128;
    localparam int unsigned RESP_BITS = 128;
    localparam int unsigned SHORT_CRC_LAST = SHORT_BITS - 9;
    localparam int unsigned LONG_CRC_FIRST = 8;
    localparam int unsigned LONG_CRC_LAST  = LONG_BITS - 9;

    typedef struct packed {
        cmd_state_e           state;
        logic [GAP_W-1:0]     idle_cnt;
        logic [TMO_W-1:0]     tmo_cnt;
        logic [POS_W-1:0]     pos;
        logic [TXC_W-1:0]     tx_cnt;
        logic [TX_BITS-1:0]   tx_sh;
        logic [RX_KEEP-1:0]   rx_sh;
        logic [RESP_BITS-1:0] resp;
    } regs_t;

    regs_t q, d;

    logic [FLAG_N-1:0]  flag_set;
    logic               crc_clr, crc_en, crc_bit;
    logic [CRC_W-1:0]   crc_val;
    logic [TX_BITS-1:0] frame;
    logic [RX_KEEP-1:0] rx_next;
    logic               gap_ok, long_rsp, has_rsp, rsp_good, ceata_hold;
    logic [POS_W-1:0]   last_pos;
    cmd_state_e         state_q;

    sdcmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_bit),
        .crc_o (crc_val)
    );

    sdcmd_flags #(.N(FLAG_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set     (flag_set),
        .clr     (flag_clr),
        .flags_o (flags_o)
    );

    always_comb begin
        d          = q;
        flag_set   = '0;
        crc_clr    = 1'b1;
        crc_en     = 1'b0;
        crc_bit    = cmd_i;
        rsp_good   = 1'b0;
        frame      = {1'b0, 1'b1, cmd_index, cmd_arg,
                      crc7_frame({2'b01, cmd_index, cmd_arg}), 1'b1};
        rx_next    = {q.rx_sh[RX_KEEP-2:0], cmd_i};
        long_rsp   = (rsp_kind == 2'b11);
        has_rsp    = rsp_kind[0];
        last_pos   = long_rsp ? POS_W'(LONG_BITS - 1) : POS_W'(SHORT_BITS - 1);
        gap_ok     = (q.idle_cnt >= GAP_W'(GAP_CYCLES - 1));
        ceata_hold = ceata_mode && !ceata_irq_en;

        if (q.state == ST_IDLE) begin
            if (q.idle_cnt != GAP_W'(GAP_CYCLES)) begin
                d.idle_cnt = q.idle_cnt + GAP_W'(1);
            end
        end else begin
            d.idle_cnt = '0;
        end

        if (!eng_en) begin
            d.state = ST_IDLE;
        end else begin
            case (q.state)
                ST_IDLE: begin
                    if (cmd_go && gap_ok) begin
                        if (wait_data) begin
                            d.state = ST_PEND;
                        end else begin
                            d.state  = ST_SEND;
                            d.tx_sh  = frame;
                            d.tx_cnt = '0;
                        end
                    end
                end
                ST_PEND: begin
                    if (data_done) begin
                        d.state  = ST_SEND;
                        d.tx_sh  = frame;
                        d.tx_cnt = '0;
                    end
                end
                ST_SEND: begin
                    d.tx_sh  = {q.tx_sh[TX_BITS-2:0], 1'b1};
                    d.tx_cnt = q.tx_cnt + TXC_W'(1);
                    if (q.tx_cnt == TXC_W'(TX_BITS - 1)) begin
                        flag_set[FL_SENT] = 1'b1;
                        d.tmo_cnt = '0;
                        d.state   = has_rsp ? ST_WAIT : ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (!cmd_i) begin
                        crc_clr = 1'b0;
                        crc_en  = !long_rsp;
                        d.rx_sh = rx_next;
                        d.pos   = POS_W'(1);
                        d.state = ST_RECV;
                    end else if (q.tmo_cnt == TMO_W'(RSP_TIMEOUT - 1)) begin
                        flag_set[FL_TMO] = 1'b1;
                        d.state = ST_IDLE;
                    end else begin
                        d.tmo_cnt = q.tmo_cnt + TMO_W'(1);
                    end
                end
                ST_RECV: begin
                    crc_clr = 1'b0;
                    crc_en  = long_rsp
                            ? (q.pos >= POS_W'(LONG_CRC_FIRST) && q.pos <= POS_W'(LONG_CRC_LAST))
                            : (q.pos <= POS_W'(SHORT_CRC_LAST));
                    d.rx_sh = rx_next;
                    d.pos   = q.pos + POS_W'(1);
                    if (q.pos == last_pos) begin
                        rsp_good = rx_next[0] && (rsp_nocrc || (crc_val == rx_next[7:1]));
                        d.resp   = long_rsp ? {rx_next[RX_KEEP-1:1], 1'b0}
                                            : {rx_next[39:8], 96'd0};
                        if (rsp_good) begin
                            flag_set[FL_OK] = 1'b1;
                            if (ceata_hold) begin
                                d.state = ceata_cmpl_wait ? ST_CMPL : ST_PEND;
                            end else begin
                                d.state = ST_IDLE;
                            end
                        end else begin
                            flag_set[FL_CRCERR] = 1'b1;
                            d.state = ST_IDLE;
                        end
                    end
                end
                ST_CMPL: begin
                    if (!cmd_i) begin
                        flag_set[FL_CMPL] = 1'b1;
                        d.state = ST_IDLE;
                    end
                end
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign state_q = q.state;
    assign cmd_oe  = (q.state == ST_SEND);
    assign cmd_o   = cmd_oe ? q.tx_sh[TX_BITS-1] : 1'b1;
    assign rsp_w0  = q.resp[127:96];
    assign rsp_w1  = q.resp[95:64];
    assign rsp_w2  = q.resp[63:32];
    assign rsp_w3  = q.resp[31:0];

endmodule

// File: rtl/sdcmd_engine_chk.sv
module sdcmd_engine_chk
    import sdcmd_pkg::*;
#(
    parameter int unsigned GAP_CYCLES = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_en,
    input logic       cmd_oe,
    input logic       cmd_o,
    input logic [4:0] flags_o,
    input logic [4:0] flag_clr,
    input cmd_state_e state_q
);

    int unsigned idle_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_run <= 0;
        end else if (state_q == ST_IDLE) begin
            if (idle_run < GAP_CYCLES) idle_run <= idle_run + 1;
        end else begin
            idle_run <= 0;
        end
    end

    // R3
    gap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && idle_run < GAP_CYCLES - 1) |=> (state_q == ST_IDLE));

    // R12
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_en |=> !cmd_oe);

    // R2
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_oe) |-> !cmd_o);

    // R13
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags_o & ~flag_clr)) |=>
        ((flags_o & $past(flags_o & ~flag_clr)) == $past(flags_o & ~flag_clr)));

    // R6
    timeout_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[3]) |-> ($past(state_q) == ST_WAIT));

endmodule

bind sdcmd_engine sdcmd_engine_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_en   (eng_en),
    .cmd_oe   (cmd_oe),
    .cmd_o    (cmd_o),
    .flags_o  (flags_o),
    .flag_clr (flag_clr),
    .state_q  (state_q)
);

// File: tb/sdcmd_engine_tb.sv
module sdcmd_engine_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_en = 1'b0, cmd_go = 1'b0, wait_data = 1'b0;
    logic [5:0]  cmd_index = '0;
    logic [31:0] cmd_arg = '0;
    logic [1:0]  rsp_kind = '0;
    logic        rsp_nocrc = 1'b0, ceata_mode = 1'b0, ceata_irq_en = 1'b0, ceata_cmpl_wait = 1'b0;
    logic        data_done = 1'b0;
    logic [4:0]  flag_clr = '0;
    logic        cmd_i = 1'b1;
    logic        cmd_o, cmd_oe;
    logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
    logic [4:0]  flags_o;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    sdcmd_engine u_dut (
        .clk(clk), .rst_n(rst_n), .eng_en(eng_en), .cmd_go(cmd_go), .wait_data(wait_data),
        .cmd_index(cmd_index), .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .rsp_nocrc(rsp_nocrc),
        .ceata_mode(ceata_mode), .ceata_irq_en(ceata_irq_en), .ceata_cmpl_wait(ceata_cmpl_wait),
        .data_done(data_done), .flag_clr(flag_clr), .cmd_i(cmd_i), .cmd_o(cmd_o), .cmd_oe(cmd_oe),
        .rsp_w0(rsp_w0), .rsp_w1(rsp_w1), .rsp_w2(rsp_w2), .rsp_w3(rsp_w3), .flags_o(flags_o)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7b(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c;
        c = '0;
        for (int i = hi; i >= lo; i--) begin
            logic fb;
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] host_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] f;
        f = {88'h0, 1'b0, 1'b1, idx, arg, 7'h0, 1'b1};
        f[7:1] = crc7b(f, 47, 8);
        return f[47:0];
    endfunction

    // ---------------- behavioural reference model ----------------
    localparam int MI = 0, MP = 1, MS = 2, MW = 3, MR = 4, MC = 5;
    int           m_st = MI, m_idle = 0, m_wait = 0, m_nidle = 0;
    bit           txq[$];
    bit           rxq[$];
    logic [4:0]   m_flags = '0, m_set;
    logic [127:0] m_resp = '0;

    task automatic load_tx();
        logic [47:0] f;
        f = host_frame(cmd_index, cmd_arg);
        txq.delete();
        for (int i = 47; i >= 0; i--) txq.push_back(f[i]);
    endtask

    task automatic finish_rx();
        logic [135:0] v;
        logic [6:0]   c;
        logic         lng, good;
        v = '0;
        foreach (rxq[i]) v = {v[134:0], rxq[i]};
        lng  = (rsp_kind == 2'b11);
        c    = lng ? crc7b(v, 127, 8) : crc7b(v, 47, 8);
        good = v[0] && (rsp_nocrc || c == v[7:1]);
        m_resp = lng ? {v[127:1], 1'b0} : {v[39:8], 96'h0};
        if (good) begin
            m_set[1] = 1'b1;
            if (ceata_mode && !ceata_irq_en) m_st = ceata_cmpl_wait ? MC : MP;
            else m_st = MI;
        end else begin
            m_set[2] = 1'b1;
            m_st = MI;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = MI; m_idle = 0; m_wait = 0; m_flags = '0; m_resp = '0;
            txq.delete(); rxq.delete();
        end else begin
            m_set   = '0;
            m_nidle = (m_st == MI) ? ((m_idle < 8) ? m_idle + 1 : 8) : 0;
            if (!eng_en) begin
                m_st = MI;
            end else begin
                case (m_st)
                    MI: if (cmd_go && m_idle >= 7) begin
                            if (wait_data) m_st = MP;
                            else begin load_tx(); m_st = MS; end
                        end
                    MP: if (data_done) begin load_tx(); m_st = MS; end
                    MS: begin
                            void'(txq.pop_front());
                            if (txq.size() == 0) begin
                                m_set[0] = 1'b1;
                                m_wait = 0;
                                m_st = rsp_kind[0] ? MW : MI;
                            end
                        end
                    MW: if (!cmd_i) begin
                            rxq.delete(); rxq.push_back(1'b0); m_st = MR;
                        end else if (m_wait == 63) begin
                            m_set[3] = 1'b1; m_st = MI;
                        end else m_wait++;
                    MR: begin
                            rxq.push_back(cmd_i);
                            if (rxq.size() == ((rsp_kind == 2'b11) ? 136 : 48)) finish_rx();
                        end
                    MC: if (!cmd_i) begin m_set[4] = 1'b1; m_st = MI; end
                    default: m_st = MI;
                endcase
            end
            m_idle  = m_nidle;
            m_flags = (m_flags & ~flag_clr) | m_set;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk("R2 cmd_oe vs model", {127'h0, cmd_oe}, {127'h0, (m_st == MS)});
            chk("R2 cmd_o vs model", {127'h0, cmd_o}, {127'h0, (m_st == MS) ? txq[0] : 1'b1});
            chk("R13 flags vs model", {123'h0, flags_o}, {123'h0, m_flags});
            chk("R7 response words vs model", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, m_resp);
        end
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [1:0] kind);
        cmd_index = idx; cmd_arg = arg; rsp_kind = kind; cmd_go = 1'b1;
        @(negedge clk);
        cmd_go = 1'b0;
    endtask

    task automatic wait_frame_end();
        while (!cmd_oe) @(negedge clk);
        while (cmd_oe) @(negedge clk);
    endtask

    task automatic card_send(input logic [135:0] v, input int len, input int dly);
        tick(dly);
        for (int i = len - 1; i >= 0; i--) begin
            cmd_i = v[i];
            @(negedge clk);
        end
        cmd_i = 1'b1;
    endtask

    function automatic logic [135:0] short_rsp(input logic [5:0] idx, input logic [31:0] st, input bit bad);
        logic [135:0] v;
        v = {88'h0, 1'b0, 1'b0, idx, st, 7'h0, 1'b1};
        v[7:1] = crc7b(v, 47, 8);
        if (bad) v[1] = ~v[1];
        return v;
    endfunction

    function automatic logic [135:0] long_rsp(input logic [119:0] body);
        logic [135:0] v;
        v = {1'b0, 1'b0, 6'h3F, body, 7'h0, 1'b1};
        v[7:1] = crc7b(v, 127, 8);
        return v;
    endfunction

    task automatic clear_all();
        flag_clr = 5'h1F;
        @(negedge clk);
        flag_clr = 5'h00;
    endtask

    initial begin
        logic [47:0]  got, expf;
        int           nbits;
        logic [135:0] lv;
        logic [119:0] body;

        // R1 reset state
        tick(3);
        chk("R1 reset outputs", {cmd_oe, cmd_o, flags_o, rsp_w0}, {1'b0, 1'b1, 5'h00, 32'h0});
        eng_en = 1'b1;
        rst_n  = 1'b1;

        // R3 go too early after reset is ignored
        issue(6'h02, 32'h0, 2'b00);
        nbits = 0;
        for (int i = 0; i < 12; i++) begin
            if (cmd_oe) nbits++;
            @(negedge clk);
        end
        chk("R3 early go ignored", nbits, 0);

        // R2 frame content, R5 no-response kind 00
        issue(6'h11, 32'hA5C3_0F96, 2'b00);
        got = '0; nbits = 0;
        while (!cmd_oe) @(negedge clk);
        while (cmd_oe) begin
            got = {got[46:0], cmd_o}; nbits++;
            @(negedge clk);
        end
        expf = host_frame(6'h11, 32'hA5C3_0F96);
        chk("R2 frame length", nbits, 48);
        chk("R2 frame bits", got, expf);
        chk("R2 sent flag", flags_o, 5'b00001);
        tick(70);
        chk("R5 kind 00 gives no timeout", flags_o[3], 1'b0);

        // R5 kind 10 also no response
        issue(6'h07, 32'h1234_5678, 2'b10);
        wait_frame_end();
        tick(70);
        chk("R5 kind 10 gives no timeout", flags_o[3], 1'b0);

        // R13 clear
        clear_all();
        chk("R13 clear mask clears flags", flags_o, 5'h00);

        // R6 timeout boundary
        tick(2);
        issue(6'h0D, 32'h0001_0000, 2'b01);
        wait_frame_end();
        tick(63);
        chk("R6 no timeout after 63 cycles", flags_o[3], 1'b0);
        tick(1);
        chk("R6 timeout after 64 cycles", flags_o[3], 1'b1);

        // R7 short response, good CRC
        clear_all(); tick(10);
        issue(6'h0D, 32'h0001_0000, 2'b01);
        wait_frame_end();
        card_send(short_rsp(6'h0D, 32'h0000_0920, 0), 48, 3);
        chk("R7 ok flag", flags_o[2:1], 2'b01);
        chk("R7 short payload", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {32'h0000_0920, 96'h0});

        // R9 bad CRC then skip
        clear_all(); tick(10);
        issue(6'h0D, 32'h0001_0000, 2'b01);
        wait_frame_end();
        card_send(short_rsp(6'h0D, 32'hDEAD_0001, 1), 48, 5);
        chk("R9 crc fail flag", flags_o[2:1], 2'b10);
        clear_all(); tick(10);
        rsp_nocrc = 1'b1;
        issue(6'h0D, 32'h0001_0000, 2'b01);
        wait_frame_end();
        card_send(short_rsp(6'h0D, 32'hDEAD_0002, 1), 48, 2);
        chk("R9 skip crc accepts", flags_o[2:1], 2'b01);
        rsp_nocrc = 1'b0;

        // R8 long response
        clear_all(); tick(10);
        body = {32'hF1E2_D3C4, 32'hB5A6_9788, 32'h7960_5A4B, 24'h3C2D1E};
        lv = long_rsp(body);
        issue(6'h02, 32'h0, 2'b11);
        wait_frame_end();
        card_send(lv, 136, 4);
        chk("R8 long ok flag", flags_o[2:1], 2'b01);
        chk("R8 long payload", {rsp_w0, rsp_w1, rsp_w2, rsp_w3}, {body, lv[7:1], 1'b0});

        // R4 wait for data end
        clear_all(); tick(10);
        wait_data = 1'b1;
        issue(6'h19, 32'h0000_0040, 2'b00);
        nbits = 0;
        for (int i = 0; i < 20; i++) begin
            if (cmd_oe) nbits++;
            @(negedge clk);
        end
        chk("R4 held in pend", nbits, 0);
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
        chk("R4 send after data end", cmd_oe, 1'b1);
        wait_data = 1'b0;
        wait_frame_end();

        // R10 CE-ATA completion wait
        clear_all(); tick(10);
        ceata_mode = 1'b1; ceata_irq_en = 1'b0; ceata_cmpl_wait = 1'b1;
        issue(6'h3C, 32'h0000_1234, 2'b01);
        wait_frame_end();
        card_send(short_rsp(6'h3C, 32'h0000_0900, 0), 48, 3);
        tick(6);
        chk("R10 no completion yet", flags_o[4], 1'b0);
        cmd_i = 1'b0;
        @(negedge clk);
        cmd_i = 1'b1;
        chk("R10 completion flag", flags_o[4], 1'b1);

        // R11 CE-ATA to pend, resend on data end, then R12 abort
        clear_all(); tick(10);
        ceata_cmpl_wait = 1'b0;
        issue(6'h3C, 32'h0000_1234, 2'b01);
        wait_frame_end();
        card_send(short_rsp(6'h3C, 32'h0000_0900, 0), 48, 3);
        nbits = 0;
        for (int i = 0; i < 5; i++) begin
            if (cmd_oe) nbits++;
            @(negedge clk);
        end
        chk("R11 waits in pend", nbits, 0);
        clear_all();
        data_done = 1'b1;
        @(negedge clk);
        data_done = 1'b0;
        chk("R11 resend on data end", cmd_oe, 1'b1);
        tick(10);
        eng_en = 1'b0;
        @(negedge clk);
        chk("R12 abort drops cmd_oe", cmd_oe, 1'b0);
        tick(60);
        chk("R12 aborted frame sets no flag", flags_o, 5'h00);
        ceata_mode = 1'b0;
        eng_en = 1'b1;
        tick(10);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule